// File: doc/BRIEF.md
# Dual-Modulus Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It sits after an external divide-by-8 RF prescaler and divides that prescaler's output down to the phase-comparison rate. The division ratio is set by a main count M and a swallow count S. A 32/33 dual-modulus stage, built here as a synchronous counter, runs at modulus 33 for the first S of its cycles in each output period. It runs at modulus 32 for the rest of the M cycles. Each output period is therefore 32*M + S input clocks long, and the ratio from the oscillator to the comparison rate is 8*(32M+S).

A control latch presents a new M/S pair together with a one-cycle load strobe and a narrow-mode flag. In narrow mode the main word is treated as 9 bits wide, and its top bit is ignored. A captured value below 32 is raised to 32. A captured pair waits in a pending register and only takes effect when the current period ends, so a period is never cut short. The block emits a one-cycle pulse at the end of every period and exposes the modulus-control level it applies to its own 32/33 stage.

Top module: `swallow_divider`

## Requirements
- R1: In wide mode (`narrow_mode`=0), once a pair M (32..1023) and S (0..31) is in effect, consecutive `div_pulse` assertions are exactly 32*M+S clock cycles apart.
- R2: `div_pulse` is high for exactly one clock cycle per output period, and that cycle is the last cycle of the period.
- R3: `mod_sel` is 1 (modulus 33) for the first 33*S clock cycles of each period and 0 for the rest of the period, so it is never high when S=0.
- R4: When `narrow_mode`=1 at the load, bit 9 of `main_word` is ignored and M is taken from bits 8..0, for example 554 (0x22A) gives M=42.
- R5: A main value below 32 after the narrow-mode masking is used as 32, in both modes.
- R6: A pair loaded in the middle of a period does not change that period's length. It applies from the next period onward.
- R7: During reset `div_pulse` is 0 and `mod_sel` equals (RST_S != 0). After reset the pair RST_M/RST_S (defaults 32 and 0) is in effect, and the first pulse arrives 32*RST_M+RST_S-1 clock edges after reset is released.
- R8: Changes on `main_word`, `swallow_word` and `narrow_mode` without `load_en` have no effect on the period length or on the `mod_sel` pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | One-cycle strobe that captures the word inputs into the pending pair |
| narrow_mode | input | 1 | 1: main word treated as 9 bits (bit 9 ignored) |
| main_word | input | 10 | Main count M |
| swallow_word | input | 5 | Swallow count S |
| div_pulse | output | 1 | One-cycle pulse at the end of each output period |
| mod_sel | output | 1 | Modulus control of the 32/33 stage: 1 selects 33 |

## Verification
The properties rely on the fact that a loaded swallow value never exceeds the effective main value. That fact always holds, because M is clamped to at least 32 and S is at most 31, so the swallow phase always ends before the last prescaler cycle. They also rely on `load_en` being a clean single-cycle strobe that is synchronous to `clk_pre`. The stimulus keeps to this. It drives loads and word changes half a cycle away from the rising edge and only a few cycles after a pulse, so a load never falls on a period boundary. It also keeps periods short enough that two consecutive periods can be measured for every vector.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  // Modulus selection for the dual-modulus stage
  typedef enum logic {
    MOD_BASE  = 1'b0,
    MOD_PLUS1 = 1'b1
  } mod_e;

  // Drop the top main bit when the narrow format is in use
  function automatic int unsigned fold_main(int unsigned m, bit narrow, int unsigned narrow_w);
    int unsigned mask;
    mask = (32'd1 << narrow_w) - 32'd1;
    return narrow ? (m & mask) : m;
  endfunction

  // Raise an illegal small main value to the minimum
  function automatic int unsigned clamp_main(int unsigned m, int unsigned lo);
    return (m < lo) ? lo : m;
  endfunction

  // Number of input clocks in one output period
  function automatic int unsigned period_clocks(int unsigned m, int unsigned s, int unsigned base);
    return base * m + s;
  endfunction

endpackage

// File: rtl/swdiv_cfg.sv
module swdiv_cfg #(
  parameter int M_W   = 10,
  parameter int S_W   = 5,
  parameter int M_MIN = 32,
  parameter int RST_M = 32,
  parameter int RST_S = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic           narrow_mode,
  input  logic [M_W-1:0] main_word,
  input  logic [S_W-1:0] swallow_word,
  output logic [M_W-1:0] pend_m,
  output logic [S_W-1:0] pend_s
);
  localparam int NARROW_W = M_W - 1;

  logic [M_W-1:0] m_fold;
  logic [M_W-1:0] m_legal;

  always_comb begin
    m_fold  = M_W'(swdiv_pkg::fold_main(32'(main_word), narrow_mode, NARROW_W));
    m_legal = M_W'(swdiv_pkg::clamp_main(32'(m_fold), M_MIN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_m <= M_W'(RST_M);
      pend_s <= S_W'(RST_S);
    end else if (load_en) begin
      pend_m <= m_legal;
      pend_s <= swallow_word;
    end
  end
endmodule

// File: rtl/swdiv_dualmod.sv
module swdiv_dualmod #(
  parameter int S_W      = 5,
  parameter bit RST_HIGH = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  swdiv_pkg::mod_e mod_next,
  output logic            pre_tc
);
  localparam int BASE = 1 << S_W;
  localparam int CW   = S_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] start_val;

  always_comb begin
    start_val = (mod_next == swdiv_pkg::MOD_PLUS1) ? CW'(BASE) : CW'(BASE - 1);
    pre_tc    = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= RST_HIGH ? CW'(BASE) : CW'(BASE - 1);
    else if (pre_tc) cnt <= start_val;
    else             cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/swdiv_ctl.sv
module swdiv_ctl #(
  parameter int M_W   = 10,
  parameter int S_W   = 5,
  parameter int RST_M = 32,
  parameter int RST_S = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_tc,
  input  logic [M_W-1:0]  pend_m,
  input  logic [S_W-1:0]  pend_s,
  output swdiv_pkg::mod_e mod_now,
  output swdiv_pkg::mod_e mod_next,
  output logic            period_end
);
  logic [M_W-1:0] mn_cnt, mn_nxt;
  logic [S_W-1:0] sw_cnt, sw_nxt, sw_dec;

  always_comb begin
    period_end = pre_tc && (mn_cnt == M_W'(1));
    sw_dec     = (sw_cnt != '0) ? sw_cnt - S_W'(1) : '0;
    if (period_end) begin
      sw_nxt = pend_s;
      mn_nxt = pend_m;
    end else if (pre_tc) begin
      sw_nxt = sw_dec;
      mn_nxt = mn_cnt - M_W'(1);
    end else begin
      sw_nxt = sw_cnt;
      mn_nxt = mn_cnt;
    end
    mod_now  = (sw_cnt != '0) ? swdiv_pkg::MOD_PLUS1 : swdiv_pkg::MOD_BASE;
    mod_next = (sw_nxt != '0) ? swdiv_pkg::MOD_PLUS1 : swdiv_pkg::MOD_BASE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mn_cnt <= M_W'(RST_M);
      sw_cnt <= S_W'(RST_S);
    end else begin
      mn_cnt <= mn_nxt;
      sw_cnt <= sw_nxt;
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int M_W   = 10,
  parameter int S_W   = 5,
  parameter int M_MIN = 32,
  parameter int RST_M = 32,
  parameter int RST_S = 0
) (
  input  logic           clk_pre,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic           narrow_mode,
  input  logic [M_W-1:0] main_word,
  input  logic [S_W-1:0] swallow_word,
  output logic           div_pulse,
  output logic           mod_sel
);
  localparam bit RST_HIGH = (RST_S != 0);

  logic [M_W-1:0]  pend_m;
  logic [S_W-1:0]  pend_s;
  logic            pre_tc;
  logic            period_end;
  swdiv_pkg::mod_e mod_now;
  swdiv_pkg::mod_e mod_next;

  swdiv_cfg #(
    .M_W(M_W), .S_W(S_W), .M_MIN(M_MIN), .RST_M(RST_M), .RST_S(RST_S)
  ) u_cfg (
    .clk(clk_pre), .rst_n(rst_n), .load_en(load_en), .narrow_mode(narrow_mode),
    .main_word(main_word), .swallow_word(swallow_word),
    .pend_m(pend_m), .pend_s(pend_s)
  );

  swdiv_dualmod #(
    .S_W(S_W), .RST_HIGH(RST_HIGH)
  ) u_dm (
    .clk(clk_pre), .rst_n(rst_n), .mod_next(mod_next), .pre_tc(pre_tc)
  );

  swdiv_ctl #(
    .M_W(M_W), .S_W(S_W), .RST_M(RST_M), .RST_S(RST_S)
  ) u_ctl (
    .clk(clk_pre), .rst_n(rst_n), .pre_tc(pre_tc), .pend_m(pend_m), .pend_s(pend_s),
    .mod_now(mod_now), .mod_next(mod_next), .period_end(period_end)
  );

  assign div_pulse = period_end;
  assign mod_sel   = (mod_now == swdiv_pkg::MOD_PLUS1);
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int M_W   = 10,
  parameter int M_MIN = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load_en,
  input logic           narrow_mode,
  input logic           div_pulse,
  input logic           mod_sel,
  input logic           pre_tc,
  input logic [M_W-1:0] pend_m
);
  // R2: a pulse never lasts two cycles
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R3: the last cycle of a period always runs at the base modulus
  assert_base_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> !mod_sel);

  // R3: the plus-one modulus only begins right after a period boundary
  assert_mod_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_sel) |-> $past(div_pulse));

  // R3: the modulus level changes only when a prescaler cycle completes
  assert_mod_on_tc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_sel) |-> $past(pre_tc));

  // R4: a narrow-mode load leaves the top main bit clear
  assert_narrow_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && narrow_mode) |=> (pend_m[M_W-1] == 1'b0));

  // R5: the pending main value is never below the minimum
  assert_min_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_m >= M_W'(M_MIN));

  // R8: without a load the pending main value holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(pend_m));
endmodule

bind swallow_divider swallow_divider_chk #(
  .M_W(M_W), .M_MIN(M_MIN)
) u_chk (
  .clk(clk_pre), .rst_n(rst_n), .load_en(load_en), .narrow_mode(narrow_mode),
  .div_pulse(div_pulse), .mod_sel(mod_sel), .pre_tc(pre_tc), .pend_m(pend_m)
);

// File: tb/swallow_divider_bench.sv
`timescale 1ns/1ps
module swallow_divider_bench;
  localparam int NV = 8;
  // stimulus: narrow flag, main word, swallow word; expected period length
  localparam int VN [NV] = '{0, 0, 0, 1, 0, 1, 0, 0};
  localparam int VM [NV] = '{40, 40, 33, 554, 20, 517, 600, 32};
  localparam int VS [NV] = '{0, 31, 5, 7, 3, 0, 17, 31};
  localparam int VE [NV] = '{1280, 1311, 1061, 1351, 1027, 1024, 19217, 1055};

  logic       clk_pre = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic       narrow_mode = 1'b0;
  logic [9:0] main_word = '0;
  logic [4:0] swallow_word = '0;
  logic       div_pulse;
  logic       mod_sel;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int last_cyc = 0;
  int last_len = 0;
  int last_hi = 0;
  int acc_hi = 0;
  int pulse_cnt = 0;
  int dbl_cnt = 0;
  bit prev_p = 1'b0;

  swallow_divider u_swallow_divider (
    .clk_pre(clk_pre), .rst_n(rst_n), .load_en(load_en), .narrow_mode(narrow_mode),
    .main_word(main_word), .swallow_word(swallow_word),
    .div_pulse(div_pulse), .mod_sel(mod_sel)
  );

  always #5 clk_pre = ~clk_pre;

  always @(posedge clk_pre) cyc <= cyc + 1;

  always @(negedge clk_pre) begin
    if (rst_n) begin
      acc_hi = acc_hi + (mod_sel ? 1 : 0);
      if (div_pulse) begin
        if (prev_p) dbl_cnt = dbl_cnt + 1;
        last_len  = cyc - last_cyc;
        last_cyc  = cyc;
        last_hi   = acc_hi;
        acc_hi    = 0;
        pulse_cnt = pulse_cnt + 1;
      end
      prev_p = div_pulse;
    end else begin
      acc_hi = 0;
      prev_p = 1'b0;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  always @(posedge clk_pre) begin
    if (cyc > 190000) begin
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog actual %0d expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_err = n_err + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_pre);
      #1;
    end
  endtask

  task automatic wait_pulse();
    int start;
    int guard;
    start = pulse_cnt;
    guard = 0;
    while (pulse_cnt == start && guard < 25000) begin
      step(1);
      guard = guard + 1;
    end
    if (pulse_cnt == start) chk("R2 pulse timeout", 0, 1);
  endtask

  function automatic string vtag(int i);
    case (i)
      1, 7:    return "R3";
      3:       return "R4";
      4, 5:    return "R5";
      default: return "R1";
    endcase
  endfunction

  initial begin
    int prev_n;
    int rel;
    // R7: reset state and first period
    step(3);
    chk("R7 pulse in reset", int'(div_pulse), 0);
    chk("R7 mod_sel in reset", int'(mod_sel), 0);
    rst_n = 1'b1;
    rel = cyc;
    wait_pulse();
    chk("R7 first pulse delay", last_cyc - rel, 1023);
    wait_pulse();
    chk("R7 default period", last_len, 1024);
    prev_n = 1024;

    for (int i = 0; i < NV; i++) begin
      wait_pulse();
      step(3);
      narrow_mode  = VN[i][0];
      main_word    = 10'(VM[i]);
      swallow_word = 5'(VS[i]);
      load_en      = 1'b1;
      step(1);
      load_en      = 1'b0;
      wait_pulse();
      chk("R6 period holding the load", last_len, prev_n);
      wait_pulse();
      chk(vtag(i), last_len, VE[i]);
      chk("R3 plus-one cycles", last_hi, 33 * VS[i]);
      prev_n = VE[i];
    end

    // R8: word changes without a load are ignored
    wait_pulse();
    step(2);
    narrow_mode  = 1'b1;
    main_word    = 10'd200;
    swallow_word = 5'd9;
    wait_pulse();
    wait_pulse();
    chk("R8 period without load", last_len, 1055);
    chk("R8 plus-one without load", last_hi, 33 * 31);

    // R7: reset in mid-run restores the default pair
    step(5);
    rst_n = 1'b0;
    step(2);
    chk("R7 pulse in second reset", int'(div_pulse), 0);
    chk("R7 mod_sel in second reset", int'(mod_sel), 0);
    rst_n = 1'b1;
    rel = cyc;
    wait_pulse();
    chk("R7 delay after second reset", last_cyc - rel, 1023);
    wait_pulse();
    chk("R7 period after second reset", last_len, 1024);

    // R2: pulses are single-cycle
    chk("R2 double-width pulses", dbl_cnt, 0);
    summary();
    $finish;
  end
endmodule